// File: doc/BRIEF.md
# Video interrupt status controller

This block collects two timing events from a 640x480, 60 Hz display controller and turns them into one active-low interrupt request for a host CPU. The first event is the vertical-sync pulse, which arrives once per frame. The second is a scanline match, raised at the start of the line whose number equals a programmable compare value. The block records each event in a status register. It also holds an enable register that decides which pending events drive the request line.

Status bits are set on every event, whatever the enables hold. The enables only gate the request. A pending bit stays set until the host writes a 1 to it, so a handler that writes back the value it read acknowledges everything that was pending. For that reason a handler should write only the bits it has serviced.

A simple synchronous host bus reaches three registers: status, enable and line compare. Reads are combinational from the current register values, and writes take effect on the clock edge.

Top module: `vid_irq_ctrl`

## Requirements
- R1: After reset, the status, enable and line-compare registers all read zero and `irq_no_o` is high.
- R2: A one-cycle `vsync_evt_i` pulse sets status bit 0 on that clock edge. This happens whether enable bit 0 is set or not.
- R3: Status bit 1 is set on an edge where `line_start_i` is high and `line_num_i` equals the 9-bit line-compare value. It is not set on other lines, and it is not set while `line_start_i` is low.
- R4: `irq_no_o` is registered. It is low exactly one clock after a cycle in which some status bit and its enable bit are both 1, and high one clock after a cycle in which no such pair exists.
- R5: A write to the status register (address 0) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R6: If an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R7: The register map is: address 0 is status, address 1 is enable (bit 0 vsync, bit 1 line), and address 2 is line compare in bits 8:0. Bits above these fields read zero and ignore writes, and address 3 reads zero.
- R8: An event whose enable bit is 0 sets its status bit but leaves `irq_no_o` high. Setting the enable bit later drives `irq_no_o` low on the clock after the enable write.
- R9: Writing the enable register does not change the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_evt_i | input | 1 | One-cycle vertical-sync event |
| line_start_i | input | 1 | One-cycle strobe at the start of each scanline |
| line_num_i | input | LINE_W | Number of the line that is starting |
| bus_sel_i | input | 1 | Host bus access strobe |
| bus_we_i | input | 1 | Host bus write, when high together with select |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| irq_no_o | output | 1 | Interrupt request to the CPU, active low, registered |

## Verification
The bench builds the block with its default parameters: a 9-bit line number and a 16-bit data bus. With these values the full-range compare values 479 and 511 can be checked, and writes of all ones show that upper bits are dropped. During the random phase the line numbers and compare values are kept within 0 to 3. This makes scanline matches frequent, so events often land in the same cycle as clears and enable changes. A directed stub frame of 480 lines followed by a vertical sync checks both events over one full frame.

// File: rtl/vid_irq_pkg.sv
package vid_irq_pkg;
  localparam int NSRC      = 2;
  localparam int SRC_VSYNC = 0;
  localparam int SRC_LINE  = 1;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS  = 2'd0,
    REG_ENABLE  = 2'd1,
    REG_LINECMP = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/vid_irq_line_match.sv
module vid_irq_line_match #(
  parameter int LINE_W = 9
) (
  input  logic              line_start_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic [LINE_W-1:0] cmp_i,
  output logic              hit_o
);
  assign hit_o = line_start_i && (line_num_i == cmp_i);
endmodule

// File: rtl/vid_irq_status.sv
module vid_irq_status #(
  parameter int NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[i]) bit_q <= 1'b1;  // set beats clear
      else if (clr_i[i]) bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end
endmodule

// File: rtl/vid_irq_req.sv
module vid_irq_req #(
  parameter int NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] status_i,
  input  logic [NSRC-1:0] en_i,
  output logic            irq_no_o
);
  logic irq_nq;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_nq <= 1'b1;
    else         irq_nq <= ~|(status_i & en_i);
  end
  assign irq_no_o = irq_nq;
endmodule

// File: rtl/vid_irq_ctrl.sv
module vid_irq_ctrl #(
  parameter int LINE_W = 9,
  parameter int DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vsync_evt_i,
  input  logic                          line_start_i,
  input  logic [LINE_W-1:0]             line_num_i,
  input  logic                          bus_sel_i,
  input  logic                          bus_we_i,
  input  logic [vid_irq_pkg::ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  output logic                          irq_no_o
);
  import vid_irq_pkg::*;

  logic [NSRC-1:0]   status_q;
  logic [NSRC-1:0]   en_q;
  logic [LINE_W-1:0] cmp_q;
  logic [NSRC-1:0]   evt;
  logic [NSRC-1:0]   clr;
  logic              line_evt;
  logic              wr;

  assign wr = bus_sel_i && bus_we_i;

  vid_irq_line_match #(.LINE_W(LINE_W)) i_match (
    .line_start_i(line_start_i),
    .line_num_i  (line_num_i),
    .cmp_i       (cmp_q),
    .hit_o       (line_evt)
  );

  always_comb begin
    evt            = '0;
    evt[SRC_VSYNC] = vsync_evt_i;
    evt[SRC_LINE]  = line_evt;
  end

  assign clr = (wr && bus_addr_i == REG_STATUS) ? bus_wdata_i[NSRC-1:0] : '0;

  vid_irq_status #(.NSRC(NSRC)) i_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .clr_i   (clr),
    .status_o(status_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cmp_q <= '0;
    end else if (wr) begin
      if (bus_addr_i == REG_ENABLE)  en_q  <= bus_wdata_i[NSRC-1:0];
      if (bus_addr_i == REG_LINECMP) cmp_q <= bus_wdata_i[LINE_W-1:0];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_STATUS:  bus_rdata_o = DATA_W'(status_q);
      REG_ENABLE:  bus_rdata_o = DATA_W'(en_q);
      REG_LINECMP: bus_rdata_o = DATA_W'(cmp_q);
      default:     bus_rdata_o = '0;
    endcase
  end

  vid_irq_req #(.NSRC(NSRC)) i_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_q),
    .en_i    (en_q),
    .irq_no_o(irq_no_o)
  );
endmodule

// File: rtl/vid_irq_chk.sv
module vid_irq_chk #(
  parameter int NSRC   = 2,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vsync_evt_i,
  input logic              line_evt,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic [1:0]        bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [NSRC-1:0]   status_q,
  input logic [NSRC-1:0]   en_q,
  input logic              irq_no_o
);
  logic wr_stat;
  assign wr_stat = bus_sel_i && bus_we_i && (bus_addr_i == 2'd0);

  a_r2_vsync_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_evt_i |=> status_q[0]);

  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_evt && wr_stat && bus_wdata_i[1]) |=> status_q[1]);

  a_r5_one_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && bus_wdata_i[0] && !vsync_evt_i) |=> !status_q[0]);

  a_r5_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q[0] && !(wr_stat && bus_wdata_i[0])) |=> status_q[0]);

  a_r4_req_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_q & en_q)) |=> !irq_no_o);

  a_r4_req_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~|(status_q & en_q)) |=> irq_no_o);
endmodule

bind vid_irq_ctrl vid_irq_chk #(.NSRC(vid_irq_pkg::NSRC), .DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vsync_evt_i(vsync_evt_i),
  .line_evt   (line_evt),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .status_q   (status_q),
  .en_q       (en_q),
  .irq_no_o   (irq_no_o)
);

// File: tb/test_vid_irq_ctrl.sv
module test_vid_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 9;
  localparam int DATA_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              vsync_evt_i = 1'b0;
  logic              line_start_i = 1'b0;
  logic [LINE_W-1:0] line_num_i = '0;
  logic              bus_sel_i = 1'b0;
  logic              bus_we_i = 1'b0;
  logic [1:0]        bus_addr_i = '0;
  logic [DATA_W-1:0] bus_wdata_i = '0;
  logic [DATA_W-1:0] bus_rdata_o;
  logic              irq_no_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model
  logic [1:0]        m_st = '0;
  logic [1:0]        m_en = '0;
  logic [LINE_W-1:0] m_cmp = '0;
  logic              m_irq_n = 1'b1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vid_irq_ctrl #(.LINE_W(LINE_W), .DATA_W(DATA_W)) i_vid_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .vsync_evt_i(vsync_evt_i),
    .line_start_i(line_start_i), .line_num_i(line_num_i),
    .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_no_o(irq_no_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return DATA_W'(m_st);
      2'd1: return DATA_W'(m_en);
      2'd2: return DATA_W'(m_cmp);
      default: return '0;
    endcase
  endfunction

  // one clock: drive at negedge, check read before edge, check irq after edge
  task automatic cyc(input logic vs, input logic ls, input logic [LINE_W-1:0] ln,
                     input logic s, input logic w, input logic [1:0] a,
                     input logic [DATA_W-1:0] d);
    logic [1:0] set, clr, n_st;
    logic n_irq;
    @(negedge clk_i);
    vsync_evt_i = vs; line_start_i = ls; line_num_i = ln;
    bus_sel_i = s; bus_we_i = w; bus_addr_i = a; bus_wdata_i = d;
    #1;
    if (s && !w) chk("R7 read data", 32'(bus_rdata_o), 32'(exp_read(a)));
    set = {ls && (ln == m_cmp), vs};
    clr = (s && w && a == 2'd0) ? d[1:0] : 2'b00;
    n_st = (m_st & ~clr) | set;
    n_irq = ~|(m_st & m_en);
    @(posedge clk_i);
    m_st = n_st; m_irq_n = n_irq;
    if (s && w && a == 2'd1) m_en = d[1:0];
    if (s && w && a == 2'd2) m_cmp = d[LINE_W-1:0];
    #1;
    chk("R4 irq", 32'(irq_no_o), 32'(m_irq_n));
  endtask

  task automatic idle();             cyc(0, 0, '0, 0, 0, 2'd0, '0); endtask
  task automatic wr_reg(input logic [1:0] a, input logic [DATA_W-1:0] d);
    cyc(0, 0, '0, 1, 1, a, d);
  endtask
  task automatic rd_reg(input logic [1:0] a, input string tag, input logic [DATA_W-1:0] exp);
    @(negedge clk_i);
    vsync_evt_i = 0; line_start_i = 0; bus_sel_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1;
    chk(tag, 32'(bus_rdata_o), 32'(exp));
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20230601));
    repeat (3) @(negedge clk_i);
    chk("R1 irq at reset", 32'(irq_no_o), 32'd1);
    rst_ni = 1'b1;
    rd_reg(2'd0, "R1 status reset", 16'h0);
    rd_reg(2'd1, "R1 enable reset", 16'h0);
    rd_reg(2'd2, "R1 compare reset", 16'h0);

    // R8: masked vsync sets status, no request; enabling asserts next clock
    cyc(1, 0, '0, 0, 0, 2'd0, '0);
    idle(); idle();
    chk("R8 masked no irq", 32'(irq_no_o), 32'd1);
    rd_reg(2'd0, "R2 masked vsync sets bit0", 16'h1);
    wr_reg(2'd1, 16'h0001);
    chk("R8 irq not yet", 32'(irq_no_o), 32'd1);
    idle();
    chk("R8 irq after enable", 32'(irq_no_o), 32'd0);
    rd_reg(2'd0, "R9 enable write keeps status", 16'h1);

    // R5 write 0 keeps, write 1 clears
    wr_reg(2'd0, 16'h0000);
    rd_reg(2'd0, "R5 zero keeps", 16'h1);
    wr_reg(2'd0, 16'h0001);
    rd_reg(2'd0, "R5 one clears", 16'h0);
    chk("R4 irq released", 32'(irq_no_o), 32'd1);

    // R3 line compare at 479
    wr_reg(2'd2, 16'd479);
    cyc(0, 1, 9'd478, 0, 0, 2'd0, '0);
    cyc(0, 0, 9'd479, 0, 0, 2'd0, '0);
    rd_reg(2'd0, "R3 no match", 16'h0);
    cyc(0, 1, 9'd479, 0, 0, 2'd0, '0);
    rd_reg(2'd0, "R3 match sets bit1", 16'h2);

    // R6 set wins over clear
    cyc(0, 1, 9'd479, 1, 1, 2'd0, 16'h0002);
    rd_reg(2'd0, "R6 set beats clear", 16'h2);
    wr_reg(2'd0, 16'h0003);
    rd_reg(2'd0, "R5 write-back clears all", 16'h0);

    // R7 upper bits
    wr_reg(2'd1, 16'hFFFF);
    rd_reg(2'd1, "R7 enable width", 16'h3);
    wr_reg(2'd2, 16'hFFFF);
    rd_reg(2'd2, "R7 compare width", 16'h1FF);
    wr_reg(2'd3, 16'hFFFF);
    rd_reg(2'd3, "R7 unused address", 16'h0);
    cyc(0, 1, 9'd511, 0, 0, 2'd0, '0);
    rd_reg(2'd0, "R3 match at 511", 16'h2);
    wr_reg(2'd0, 16'hFFFF);
    rd_reg(2'd0, "R7 status upper zero", 16'h0);

    // stub frame: 480 lines then vsync
    wr_reg(2'd1, 16'h0000);
    wr_reg(2'd2, 16'd100);
    for (int ln = 0; ln < 480; ln++) begin
      cyc(0, 1, LINE_W'(ln), 0, 0, 2'd0, '0);
      idle();
    end
    cyc(1, 0, '0, 0, 0, 2'd0, '0);
    rd_reg(2'd0, "R2 R3 frame events", 16'h3);
    chk("R8 frame masked", 32'(irq_no_o), 32'd1);

    // random phase
    wr_reg(2'd2, 16'd2);
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] a;
      logic [DATA_W-1:0] d;
      logic s, w;
      a = 2'($urandom % 4);
      s = ($urandom % 3) != 0;
      w = ($urandom % 2) != 0;
      d = (a == 2'd2) ? DATA_W'($urandom % 4) : DATA_W'($urandom);
      cyc(($urandom % 8) == 0, ($urandom % 2) == 0, LINE_W'($urandom % 4), s, w, a, d);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule